// File: doc/BRIEF.md
# Constant-Divisor Modulo Reducer

The block computes the remainder of an unsigned operand divided by a divisor that is fixed when the design is elaborated. It works by magnitude reduction. A chain of compare-and-subtract steps removes successively smaller multiples of the divisor, scaled by powers of two. Each step leaves the residue unchanged, so the value that remains after the last step is the remainder.

A parameter chooses between two builds. In the pipelined build the chain is split by registers, so the clock rate depends on a single subtract step. In the flat build the whole chain is one combinational path in front of the output register. Both builds take a new operand on every clock cycle and never stall.

The operand side is a valid/ready stream. `in_ready` drops only while reset is asserted, and an operand is taken on every rising edge where both `in_valid` and `in_ready` are high. The result side has no back-pressure. `out_valid` pulses for one cycle per result, results come out in the order the operands were taken, and the consumer must capture each result in the cycle it appears.

Top module: `modconst_reduce`

## Requirements
- R1: When `out_valid` is high, `out_data` equals the accepted `in_data` modulo `DIVISOR`, taking `in_data` as unsigned.
- R2: No reduction step increases the working value or changes its residue. Every reported result is less than `DIVISOR`.
- R3: With `PIPELINED`=1, `out_valid` for an operand is high in the cycle that ends the L-th rising edge, counting the accepting edge as the first. L = `DATA_W` − KB + 2, where KB is the bit length of `DIVISOR`.
- R4: With `PIPELINED`=0, the result is registered at the accepting edge itself, so the latency is 1 cycle.
- R5: Operands may be presented on consecutive cycles with no gap. Each one yields exactly one result, and the results come out in acceptance order.
- R6: `in_ready` is 0 while `rst` is high and 1 at all other times.
- R7: `rst` is asynchronous and active high. It clears `out_valid` and `out_data` to 0 without waiting for a clock edge, and it discards every operand in flight.
- R8: Cycles where `in_valid` is low produce no result. `out_valid` is never raised without a matching accepted operand.
- R9: With `DIVISOR`=1 every result is 0.
- R10: When `DATA_W` ≤ KB, the chain collapses to a single step. In the pipelined build the latency is then 2 cycles, and the result is still correct even when `DIVISOR` exceeds the operand range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| in_valid | input | 1 | Operand present on `in_data` |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_data | input | DATA_W | Unsigned dividend |
| out_valid | output | 1 | One-cycle pulse marking a valid result |
| out_data | output | DATA_W | Remainder of the dividend by `DIVISOR` |

## Verification
The pipelined reducer (divisor 11 on 16 bits) is driven with operands that sit next to the thresholds of the reduction steps: zero, the divisor and its neighbours, the largest shifted divisor plus or minus one, the all-ones word, and an exact multiple. These cases show whether each compare uses the correct boundary and the correct shift. A back-to-back stream from a shift-register sequence tests throughput and ordering. A sparse pattern with gaps tests that bubbles produce no results. A reset while operands are in flight tests that those operands are discarded. Two further instances run the same stimulus. One is a flat build with divisor 1, which must return zero at 1-cycle latency. The other is a 4-bit pipeline whose divisor 13 nearly fills the operand range, which tests the single-step case.

// File: rtl/modc_pkg.sv
package modc_pkg;

  // number of bits needed to hold v (at least 1)
  function automatic int bits_of(input longint unsigned v);
    int n;
    longint unsigned t;
    n = 0;
    t = v;
    while (t != 0) begin
      n++;
      t = t >> 1;
    end
    return (n == 0) ? 1 : n;
  endfunction

  // compare-and-subtract steps needed to bring any w-bit value below the divisor
  function automatic int step_count(input int w, input int kb);
    return (w > kb) ? (w - kb + 1) : 1;
  endfunction

  // edges from acceptance to visible result in the pipelined build
  function automatic int pipe_latency(input int w, input int kb);
    return (w > kb) ? (w - kb + 2) : 2;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/modc_sub_stage.sv
module modc_sub_stage #(
  parameter int W       = 16,
  parameter int DIVISOR = 11,
  parameter int SHIFT   = 0
) (
  input  logic [W-1:0] w_in,
  output logic [W-1:0] w_out
);

  localparam logic [W-1:0] KV   = W'(DIVISOR);
  localparam logic [W-1:0] SUBV = KV << SHIFT;

  assign w_out = (w_in >= SUBV) ? (w_in - SUBV) : w_in;

  always_comb begin
    AST_STEP_NO_GROWTH: assert (w_out <= w_in) else $error("step increased value"); // R2
    AST_STEP_SAME_RESIDUE: assert (((w_in - w_out) % KV) == '0) else $error("step changed residue"); // R2
  end

endmodule

// File: rtl/modc_pipe_core.sv
module modc_pipe_core #(
  parameter int W       = 16,
  parameter int DIVISOR = 11,
  parameter int STAGES  = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic [W-1:0] x,
  output logic         tail_valid,
  output logic [W-1:0] tail_x
);

  logic         head_v;
  logic [W-1:0] head_x;

  // operand capture register
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      head_v <= 1'b0;
      head_x <= '0;
    end else begin
      head_v <= take;
      if (take) head_x <= x;
    end
  end

  for (genvar i = 0; i < STAGES; i++) begin : g_st
    logic         sv;
    logic [W-1:0] sx;
    logic [W-1:0] sub;
    logic         nv;
    logic [W-1:0] nx;

    if (i == 0) begin : g_head
      assign sv = head_v;
      assign sx = head_x;
    end else begin : g_link
      assign sv = g_st[i-1].nv;
      assign sx = g_st[i-1].nx;
    end

    modc_sub_stage #(
      .W(W),
      .DIVISOR(DIVISOR),
      .SHIFT(STAGES - 1 - i)
    ) u_sub (
      .w_in(sx),
      .w_out(sub)
    );

    if (i < STAGES - 1) begin : g_reg
      always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
          nv <= 1'b0;
          nx <= '0;
        end else begin
          nv <= sv;
          if (sv) nx <= sub;
        end
      end
    end else begin : g_last
      // last step feeds the output register directly
      assign nv = sv;
      assign nx = sub;
    end
  end

  assign tail_valid = g_st[STAGES-1].nv;
  assign tail_x     = g_st[STAGES-1].nx;

endmodule

// File: rtl/modc_flat_core.sv
module modc_flat_core #(
  parameter int W       = 16,
  parameter int DIVISOR = 11,
  parameter int STAGES  = 13
) (
  input  logic         take,
  input  logic [W-1:0] x,
  output logic         tail_valid,
  output logic [W-1:0] tail_x
);

  for (genvar i = 0; i < STAGES; i++) begin : g_st
    logic [W-1:0] sx;
    logic [W-1:0] nx;

    if (i == 0) begin : g_head
      assign sx = x;
    end else begin : g_link
      assign sx = g_st[i-1].nx;
    end

    modc_sub_stage #(
      .W(W),
      .DIVISOR(DIVISOR),
      .SHIFT(STAGES - 1 - i)
    ) u_sub (
      .w_in(sx),
      .w_out(nx)
    );
  end

  assign tail_valid = take;
  assign tail_x     = g_st[STAGES-1].nx;

endmodule

// File: rtl/modconst_reduce.sv
module modconst_reduce #(
  parameter int DATA_W    = 16,
  parameter int DIVISOR   = 11,
  parameter bit PIPELINED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam int KB      = modc_pkg::bits_of(longint'(DIVISOR));
  localparam int WORK_W  = modc_pkg::max_int(DATA_W, KB);
  localparam int STAGES  = modc_pkg::step_count(DATA_W, KB);
  localparam int LATENCY = PIPELINED ? modc_pkg::pipe_latency(DATA_W, KB) : 1;
  localparam int CNT_W   = $clog2(LATENCY + 2);
  localparam logic [WORK_W-1:0] KVAL = WORK_W'(DIVISOR);

  logic              accept;
  logic [WORK_W-1:0] x_wide;
  logic              tail_valid;
  logic [WORK_W-1:0] tail_x;

  assign in_ready = ~rst;
  assign accept   = in_valid & in_ready;
  assign x_wide   = WORK_W'(in_data);

  if (PIPELINED) begin : g_pipe
    modc_pipe_core #(
      .W(WORK_W),
      .DIVISOR(DIVISOR),
      .STAGES(STAGES)
    ) u_core (
      .clk(clk),
      .rst(rst),
      .take(accept),
      .x(x_wide),
      .tail_valid(tail_valid),
      .tail_x(tail_x)
    );
  end else begin : g_flat
    modc_flat_core #(
      .W(WORK_W),
      .DIVISOR(DIVISOR),
      .STAGES(STAGES)
    ) u_core (
      .take(accept),
      .x(x_wide),
      .tail_valid(tail_valid),
      .tail_x(tail_x)
    );
  end

  // result register, shared by both builds
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= tail_valid;
      if (tail_valid) out_data <= tail_x[DATA_W-1:0];
    end
  end

  // occupancy tracker used only by the properties below
  logic [CNT_W-1:0] inflight;
  always_ff @(posedge clk or posedge rst) begin
    if (rst) inflight <= '0;
    else     inflight <= inflight + CNT_W'(accept) - CNT_W'(out_valid);
  end

  AST_RESULT_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (WORK_W'(out_data) < KVAL)) else $error("result not reduced"); // R2
  AST_NO_ORPHAN_RESULT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (inflight != '0)) else $error("result without operand"); // R8
  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (rst)
    inflight <= CNT_W'(LATENCY)) else $error("too many operands in flight"); // R5

  if (!PIPELINED) begin : g_flat_chk
    AST_FLAT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      out_valid == $past(accept)) else $error("flat build latency"); // R4
  end

endmodule

// File: tb/modconst_reduce_bench.sv
module modconst_reduce_bench;

  typedef struct packed {
    logic [15:0] val;
    logic [31:0] due;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] xin = '0;
  logic [31:0] cyc = '0;

  int checks = 0;
  int errors = 0;
  int got_a = 0;
  bit done_flag = 1'b0;

  exp_t q_a[$];
  exp_t q_b[$];
  exp_t q_c[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  logic        rdy_a, rdy_b, rdy_c;
  logic        dn_a, dn_b, dn_c;
  logic [15:0] y_a;
  logic [7:0]  y_b;
  logic [3:0]  y_c;

  modconst_reduce #(.DATA_W(16), .DIVISOR(11), .PIPELINED(1'b1)) u_modconst_reduce (
    .clk(clk), .rst(rst), .in_valid(start), .in_ready(rdy_a),
    .in_data(xin), .out_valid(dn_a), .out_data(y_a));

  modconst_reduce #(.DATA_W(8), .DIVISOR(1), .PIPELINED(1'b0)) u_modconst_reduce_unit (
    .clk(clk), .rst(rst), .in_valid(start), .in_ready(rdy_b),
    .in_data(xin[7:0]), .out_valid(dn_b), .out_data(y_b));

  modconst_reduce #(.DATA_W(4), .DIVISOR(13), .PIPELINED(1'b1)) u_modconst_reduce_tiny (
    .clk(clk), .rst(rst), .in_valid(start), .in_ready(rdy_c),
    .in_data(xin[3:0]), .out_valid(dn_c), .out_data(y_c));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic mon(ref exp_t q[$], input logic dn, input logic [15:0] y,
                     input int kval, input string tag, input string vreq,
                     input string lreq);
    exp_t e;
    if (dn) begin
      if (q.size() == 0) begin
        check(1'b0, "R8", {tag, " result with no operand"}, 1, 0);
      end else begin
        e = q.pop_front();
        check(y == e.val, vreq, {tag, " remainder"}, y, e.val);
        check(y < 16'(kval), "R2", {tag, " below divisor"}, y, kval);
        check(cyc == e.due, lreq, {tag, " latency"}, cyc, e.due);
      end
    end else if (q.size() > 0 && q[0].due <= cyc) begin
      check(1'b0, lreq, {tag, " missing result"}, cyc, q[0].due);
      void'(q.pop_front());
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      if (dn_a) got_a++;
      mon(q_a, dn_a, y_a, 11, "pipe16", "R1", "R3");
      mon(q_b, dn_b, {8'h00, y_b}, 1, "flat8", "R9", "R4");
      mon(q_c, dn_c, {12'h000, y_c}, 13, "tiny4", "R10", "R10");
    end
  end

  // driver: called at a falling edge, holds the operand for one cycle
  task automatic send(input logic [15:0] v);
    exp_t e;
    xin   = v;
    start = 1'b1;
    e.val = v % 16'd11;         e.due = cyc + 14; q_a.push_back(e);
    e.val = 16'd0;              e.due = cyc + 1;  q_b.push_back(e);
    e.val = {12'h000, v[3:0] % 4'd13}; e.due = cyc + 2; q_c.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    start = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    int base;
    lf = 16'hACE1;
    #25;
    // reset state
    check(dn_a == 1'b0 && y_a == 16'd0, "R7", "reset clears output", y_a, 0);
    check(rdy_a == 1'b0 && rdy_b == 1'b0, "R6", "ready low in reset", rdy_a, 0);
    @(negedge clk); #5 rst = 1'b0;
    @(negedge clk);
    check(rdy_a && rdy_b && rdy_c, "R6", "ready high after reset", rdy_a, 1);

    // boundary operands, back to back
    send(16'd0);     send(16'd1);     send(16'd10);    send(16'd11);
    send(16'd12);    send(16'd22);    send(16'hFFFF);  send(16'd45056);
    send(16'd45055); send(16'd45057); send(16'd65527); send(16'd65526);
    idle(20);
    check(q_a.size() == 0, "R1", "boundary results drained", q_a.size(), 0);

    // dense stream
    base = got_a;
    for (int i = 0; i < 40; i++) begin
      send(lf);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    end
    idle(20);
    check(got_a - base == 40, "R5", "one result per streamed operand", got_a - base, 40);
    check(rdy_a == 1'b1, "R6", "ready stays high under load", rdy_a, 1);

    // sparse stream with bubbles
    base = got_a;
    for (int i = 0; i < 10; i++) begin
      send(lf);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      idle(3);
    end
    idle(20);
    check(got_a - base == 10, "R8", "bubbles yield no result", got_a - base, 10);

    // reset with operands in flight
    for (int i = 0; i < 6; i++) send(16'd1000 + 16'(i));
    start = 1'b0;
    #5 rst = 1'b1;
    #1;
    check(dn_a == 1'b0 && y_a == 16'd0, "R7", "async clear of pipelined output", y_a, 0);
    check(dn_b == 1'b0 && dn_c == 1'b0, "R7", "async clear of other builds", dn_b, 0);
    check(rdy_a == 1'b0, "R6", "ready low during reset", rdy_a, 0);
    q_a.delete(); q_b.delete(); q_c.delete();
    @(negedge clk); @(negedge clk); #5 rst = 1'b0;
    base = got_a;
    idle(20);
    check(got_a - base == 0, "R7", "flushed operands produce nothing", got_a - base, 0);

    // traffic after reset
    send(16'd121); send(16'd122); send(16'd7);
    idle(20);
    check(q_a.size() == 0 && q_b.size() == 0 && q_c.size() == 0, "R5",
          "all queues drained", q_a.size(), 0);

    done_flag = 1'b1;
    summary();
    $finish;
  end

endmodule